// File: doc/BRIEF.md
# Select-Byte Command Decoder with Block Lock Flags

This block sits just behind the serial bus front end of a 512-byte configuration memory. The memory is split into four 128-byte blocks and two 256-byte pages. Once the front end has shifted in the first byte after a START, it presents that byte with a one-cycle strobe. The decoder sorts the byte into one of three cases: an ordinary memory access, a protection or page command, or a byte meant for some other device. One cycle later it returns the acknowledge decision for the ninth bit.

The decoder holds four lock flags, one for each block, and a one-bit page selector. Lock and unlock commands are honoured only while the front end reports a raised voltage on the lowest slave-address pin. The query commands need no data phase. They answer through the acknowledge bit: ACK means "unlocked" or "page 0", and NOACK means "locked" or "page 1". The lock flags feed the array write path, and the page bit supplies the top address bit of the array.

Top module: `spd_guard_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `ack_valid` is 0, all four lock flags are 0 and `page_sel` is 0.
- R2: A byte with upper nibble 1010 is an array access. If bits 3..1 equal `sa_pins`, the answer is ACK with `mem_access` = 1. Otherwise the answer is NOACK with `mem_access` = 0. Bit 0 does not matter.
- R3: A byte whose upper nibble is neither 1010 nor 0110 gets NOACK and leaves the flags and the page bit unchanged.
- R4: Under nibble 0110 with bit 0 = 0, the lock codes in bits 3..1 are 001 for block 0, 100 for block 1, 101 for block 2 and 000 for block 3. With `sa0_hv` = 1 the answer is ACK and that block's flag (bit n of `wp_flags`) becomes 1.
- R5: A lock command or the unlock-all command received while `sa0_hv` = 0 gets NOACK and changes no flag.
- R6: Bits 3..1 = 011 with bit 0 = 0 under nibble 0110 is unlock-all. With `sa0_hv` = 1 the answer is ACK and all four flags clear together.
- R7: The lock codes with bit 0 = 1 query a block. The answer is ACK when the block is unlocked and NOACK when it is locked, and no state changes.
- R8: Codes 110 and 111 with bit 0 = 0 under nibble 0110 set `page_sel` to 0 and 1 respectively. Both get ACK whatever `sa0_hv` is.
- R9: Code 110 with bit 0 = 1 under nibble 0110 queries the page. The answer is ACK when `page_sel` is 0 and NOACK when it is 1, with no state change.
- R10: The remaining encodings under nibble 0110 (codes 010 with either bit 0, and 011 or 111 with bit 0 = 1) get NOACK and change no state.
- R11: A lock command with `sa0_hv` = 1 for a block that is already locked gets ACK, and the flag stays 1.
- R12: `ack_valid` is 1 in exactly the cycle after each strobe and 0 otherwise. Flags and page change only on a strobed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | One-cycle strobe: `sel_byte` holds a complete select byte |
| sel_byte | input | 8 | Select byte, bit 7 first on the wire |
| sa_pins | input | SA_W | Strapped slave-address pins |
| sa0_hv | input | 1 | Raised voltage detected on the lowest address pin |
| ack_valid | output | 1 | Acknowledge decision is valid this cycle |
| ack | output | 1 | 1 = ACK, 0 = NOACK |
| mem_access | output | 1 | Byte selected the memory array of this device |
| wp_flags | output | NUM_BLOCKS | Per-block lock flags, bit n = block n |
| page_sel | output | 1 | Selected 256-byte page |

## Verification
The embedded properties check several rules on every cycle. The strobe-to-valid timing is fixed. Flags and page hold between strobes. A lock or unlock without raised voltage leaves the flags alone, and unlock-all empties them. Queries and reserved codes change nothing, and reserved codes are refused. The properties cannot show that each of the 256 byte values lands on the right code, that the non-binary block numbering is correct, or that queries report the state left by earlier commands. The bench shows these by sweeping every byte value with both voltage levels and several pin straps, which carries the flags and page through locked, re-locked, cleared and flipped states.

// File: rtl/spdg_pkg.sv
package spdg_pkg;
   localparam logic [3:0] DTI_ARRAY = 4'b1010;
   localparam logic [3:0] DTI_GUARD = 4'b0110;
   localparam int         BLK_W     = 2;

   typedef enum logic [2:0] {
      OP_FOREIGN,
      OP_ARRAY,
      OP_LOCK,
      OP_UNLOCK_ALL,
      OP_LOCK_QUERY,
      OP_PAGE_SET,
      OP_PAGE_QUERY,
      OP_RESERVED
   } op_e;

   typedef struct packed {
      op_e              op;
      logic [BLK_W-1:0] blk;
      logic             pg;
      logic             hit;
   } cmd_t;
endpackage

// File: rtl/spdg_classify.sv
module spdg_classify
   import spdg_pkg::*;
#(
   parameter int SA_W = 3
) (
   input  logic [7:0]      sel_byte,
   input  logic [SA_W-1:0] sa_pins,
   output cmd_t            cmd
);
   logic [2:0] code;
   logic       rd;
   logic       blk_code;
   logic [BLK_W-1:0] blk_num;

   assign code = sel_byte[3:1];
   assign rd   = sel_byte[0];

   // non-binary block numbering carried in bits 3..1
   always_comb begin
      blk_code = 1'b1;
      blk_num  = '0;
      case (code)
         3'b001:  blk_num = BLK_W'(0);
         3'b100:  blk_num = BLK_W'(1);
         3'b101:  blk_num = BLK_W'(2);
         3'b000:  blk_num = BLK_W'(3);
         default: blk_code = 1'b0;
      endcase
   end

   always_comb begin
      cmd = '{op: OP_FOREIGN, blk: blk_num, pg: code[0], hit: 1'b0};
      case (sel_byte[7:4])
         DTI_ARRAY: begin
            cmd.op  = OP_ARRAY;
            cmd.hit = (code == sa_pins);
         end
         DTI_GUARD: begin
            if (blk_code)
               cmd.op = rd ? OP_LOCK_QUERY : OP_LOCK;
            else if (code == 3'b011 && !rd)
               cmd.op = OP_UNLOCK_ALL;
            else if (code[2:1] == 2'b11 && !rd)
               cmd.op = OP_PAGE_SET;
            else if (code == 3'b110 && rd)
               cmd.op = OP_PAGE_QUERY;
            else
               cmd.op = OP_RESERVED;
         end
         default: cmd.op = OP_FOREIGN;
      endcase
   end
endmodule

// File: rtl/spdg_guard_state.sv
module spdg_guard_state
   import spdg_pkg::*;
#(
   parameter int NUM_BLOCKS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  strobe,
   input  cmd_t                  cmd,
   input  logic                  hv,
   output logic [NUM_BLOCKS-1:0] locks,
   output logic                  page
);
   localparam int BW = $clog2(NUM_BLOCKS);

   generate
      for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
         logic lock_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lock_q <= 1'b0;
            else if (strobe && hv) begin
               if (cmd.op == OP_UNLOCK_ALL)
                  lock_q <= 1'b0;
               else if (cmd.op == OP_LOCK && cmd.blk == BW'(g))
                  lock_q <= 1'b1;
            end
         end
         assign locks[g] = lock_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         page <= 1'b0;
      else if (strobe && cmd.op == OP_PAGE_SET)
         page <= cmd.pg;
   end

   assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> ($stable(locks) && $stable(page)));

   assert_no_hv_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !hv && (cmd.op == OP_LOCK || cmd.op == OP_UNLOCK_ALL)) |=> $stable(locks));

   assert_unlock_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && hv && cmd.op == OP_UNLOCK_ALL) |=> (locks == '0));

   assert_query_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && (cmd.op == OP_LOCK_QUERY || cmd.op == OP_PAGE_QUERY)) |=>
         ($stable(locks) && $stable(page)));

   assert_page_only_by_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(strobe && cmd.op == OP_PAGE_SET) |=> $stable(page));
endmodule

// File: rtl/spdg_reply.sv
module spdg_reply
   import spdg_pkg::*;
#(
   parameter int NUM_BLOCKS = 4
) (
   input  cmd_t                  cmd,
   input  logic                  hv,
   input  logic [NUM_BLOCKS-1:0] locks,
   input  logic                  page,
   output logic                  ack,
   output logic                  mem_hit
);
   always_comb begin
      ack     = 1'b0;
      mem_hit = 1'b0;
      case (cmd.op)
         OP_ARRAY: begin
            ack     = cmd.hit;
            mem_hit = cmd.hit;
         end
         OP_LOCK, OP_UNLOCK_ALL: ack = hv;
         OP_LOCK_QUERY:          ack = ~locks[cmd.blk];
         OP_PAGE_SET:            ack = 1'b1;
         OP_PAGE_QUERY:          ack = ~page;
         default:                ack = 1'b0;
      endcase
   end
endmodule

// File: rtl/spd_guard_decoder.sv
module spd_guard_decoder
   import spdg_pkg::*;
#(
   parameter int SA_W       = 3,
   parameter int NUM_BLOCKS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_valid,
   input  logic [7:0]            sel_byte,
   input  logic [SA_W-1:0]       sa_pins,
   input  logic                  sa0_hv,
   output logic                  ack_valid,
   output logic                  ack,
   output logic                  mem_access,
   output logic [NUM_BLOCKS-1:0] wp_flags,
   output logic                  page_sel
);
   generate
      if (SA_W != 3) begin : g_bad_sa
         $error("SA_W must be 3: the address occupies bits 3..1");
      end
      if (NUM_BLOCKS != (1 << BLK_W)) begin : g_bad_blk
         $error("NUM_BLOCKS must match the block field width");
      end
   endgenerate

   cmd_t cmd;
   logic ack_d;
   logic mem_d;

   spdg_classify #(.SA_W(SA_W)) u_classify (
      .sel_byte (sel_byte),
      .sa_pins  (sa_pins),
      .cmd      (cmd)
   );

   spdg_reply #(.NUM_BLOCKS(NUM_BLOCKS)) u_reply (
      .cmd     (cmd),
      .hv      (sa0_hv),
      .locks   (wp_flags),
      .page    (page_sel),
      .ack     (ack_d),
      .mem_hit (mem_d)
   );

   spdg_guard_state #(.NUM_BLOCKS(NUM_BLOCKS)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (sel_valid),
      .cmd    (cmd),
      .hv     (sa0_hv),
      .locks  (wp_flags),
      .page   (page_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid  <= 1'b0;
         ack        <= 1'b0;
         mem_access <= 1'b0;
      end else begin
         ack_valid  <= sel_valid;
         ack        <= sel_valid & ack_d;
         mem_access <= sel_valid & mem_d;
      end
   end

   assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |=> ack_valid);

   assert_valid_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |=> (!ack_valid && !ack && !mem_access));

   assert_reserved_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && cmd.op == OP_RESERVED) |=> !ack);

   assert_foreign_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && cmd.op == OP_FOREIGN) |=> (!ack && !mem_access));

   assert_lock_no_hv_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !sa0_hv && (cmd.op == OP_LOCK || cmd.op == OP_UNLOCK_ALL)) |=> !ack);
endmodule

// File: tb/spd_guard_decoder_test.sv
module spd_guard_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       sel_valid;
   logic [7:0] sel_byte;
   logic [2:0] sa_pins;
   logic       sa0_hv;
   logic       ack_valid, ack, mem_access, page_sel;
   logic [3:0] wp_flags;

   int checks = 0;
   int fails  = 0;

   logic [3:0] m_lock;
   logic       m_page;

   always #4 clk = ~clk;

   spd_guard_decoder uut (
      .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_byte(sel_byte),
      .sa_pins(sa_pins), .sa0_hv(sa0_hv), .ack_valid(ack_valid), .ack(ack),
      .mem_access(mem_access), .wp_flags(wp_flags), .page_sel(page_sel)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s byte=%02h hv=%0d pins=%0d: got %0d want %0d",
                  req, sel_byte, sa0_hv, sa_pins, act, exp);
      end
   endtask

   // block index from bits 3..1 per R4, -1 when not a block code
   function automatic int blk_of(input logic [2:0] c);
      case (c)
         3'b001:  return 0;
         3'b100:  return 1;
         3'b101:  return 2;
         3'b000:  return 3;
         default: return -1;
      endcase
   endfunction

   task automatic send(input logic [7:0] b, input logic hv);
      string tag;
      int    e_ack, e_mem, bk;
      logic [2:0] c;
      c = b[3:1];
      e_ack = 0; e_mem = 0;
      bk = blk_of(c);
      if (b[7:4] == 4'b1010) begin
         tag = "R2";
         e_ack = (c == sa_pins) ? 1 : 0;
         e_mem = e_ack;
      end else if (b[7:4] != 4'b0110) begin
         tag = "R3";
      end else if (!b[0] && bk >= 0) begin
         if (!hv) tag = "R5";
         else begin
            tag = m_lock[bk] ? "R11" : "R4";
            e_ack = 1;
            m_lock[bk] = 1'b1;
         end
      end else if (!b[0] && c == 3'b011) begin
         if (!hv) tag = "R5";
         else begin
            tag = "R6";
            e_ack = 1;
            m_lock = 4'b0000;
         end
      end else if (!b[0] && c[2:1] == 2'b11) begin
         tag = "R8";
         e_ack = 1;
         m_page = c[0];
      end else if (b[0] && bk >= 0) begin
         tag = "R7";
         e_ack = m_lock[bk] ? 0 : 1;
      end else if (b[0] && c == 3'b110) begin
         tag = "R9";
         e_ack = m_page ? 0 : 1;
      end else begin
         tag = "R10";
      end

      @(negedge clk);
      sel_byte  = b;
      sa0_hv    = hv;
      sel_valid = 1'b1;
      @(negedge clk);
      sel_valid = 1'b0;
      chk({tag, " valid"}, int'(ack_valid), 1);
      chk({tag, " ack"}, int'(ack), e_ack);
      chk({tag, " mem"}, int'(mem_access), e_mem);
      chk({tag, " flags"}, int'(wp_flags), int'(m_lock));
      chk({tag, " page"}, int'(page_sel), int'(m_page));
      @(negedge clk);
      chk("R12 valid low", int'(ack_valid), 0);
      chk("R12 flags hold", int'(wp_flags), int'(m_lock));
      chk("R12 page hold", int'(page_sel), int'(m_page));
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: got timeout want completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; sel_valid = 1'b0; sel_byte = 8'h00; sa_pins = 3'd0; sa0_hv = 1'b0;
      m_lock = 4'b0000; m_page = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 valid", int'(ack_valid), 0);
      chk("R1 flags", int'(wp_flags), 0);
      chk("R1 page", int'(page_sel), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after", int'(ack_valid), 0);
      chk("R1 flags after", int'(wp_flags), 0);

      // directed: lock block 2, relock (R11), query, unlock without and with hv
      send(8'h6A, 1'b1);
      send(8'h6A, 1'b1);
      send(8'h6B, 1'b0);
      send(8'h66, 1'b0);
      send(8'h66, 1'b1);
      send(8'h6E, 1'b0);
      send(8'h6D, 1'b1);

      // exhaustive sweep across pin straps and voltage levels
      for (int p = 0; p < 3; p++) begin
         @(negedge clk);
         sa_pins = (p == 0) ? 3'd0 : (p == 1) ? 3'd5 : 3'd7;
         for (int h = 0; h < 2; h++) begin
            for (int b = 0; b < 256; b++) begin
               send(8'(b), h[0]);
            end
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule